// File: doc/BRIEF.md
# Indirect Data-Space Address Generator

This block forms the data-memory address for each load, store, port-style or stack access in a small 8-bit processor. Three 16-bit pointers come from pairs of general registers. A pointer access can use the pointer as it is, with a post-increment, with a pre-decrement, or with an unsigned 6-bit offset added. When the pointer changes, the block returns the new value, an enable, and the number of the even (low-byte) register of the pair so the register file can write it back.

The resulting address is split into three regions, in this order: the register file at the bottom of data space, then 64 I/O registers, then internal SRAM. An address above the top of SRAM raises an out-of-range flag and selects no region. Port-style I/O numbers are moved up by the size of the register-file window. A 9-bit stack pointer serves push and pop. It is loaded as a low byte and a high part. All address outputs are combinational. Only the stack pointer is a register.

Top module: `dag_top`

## Requirements
- R1: Plain mode (ptr_mode 0) sets eff_addr to the selected pointer and leaves wb_en low.
- R2: Post-increment mode (ptr_mode 1) sets eff_addr to the pointer, raises wb_en and sets wb_val to pointer+1, modulo 2^16.
- R3: Pre-decrement mode (ptr_mode 2) sets both eff_addr and wb_val to pointer-1, modulo 2^16, and raises wb_en.
- R4: Offset mode (ptr_mode 3) sets eff_addr to pointer+disp_q for Y (ptr_sel 1) and Z (ptr_sel 2), with wb_en low. For X (ptr_sel 0) disp_q is ignored and eff_addr is X.
- R5: wb_reg is 26 for X, 28 for Y and 30 for Z. ptr_sel 3 acts as Z.
- R6: region is one-hot when an access is active: bit0 for 0x00-0x1F, bit1 for 0x20-0x5F, bit2 for 0x60 up to the top of SRAM (0x15F by default).
- R7: An address above the top of SRAM sets out_of_range and leaves region all zero.
- R8: A port-style access (io_en) sets eff_addr to io_addr+0x20, which lands in the I/O region.
- R9: A push sets eff_addr to sp, and sp is one lower after the clock edge, wrapping modulo 2^9.
- R10: A pop sets eff_addr to sp+1, and sp takes that value after the clock edge.
- R11: Sources are ranked push, then pop, then io_en, then ptr_en. wb_en is high only when the pointer access is the chosen source.
- R12: sp resets to 0. sp_wr_lo loads sp[7:0] from sp_wdata and sp_wr_hi loads sp[8] from sp_wdata[0]. A load overrides a push or pop in the same cycle.
- R13: With no access active, region is zero and out_of_range and wb_en are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ptr_en | input | 1 | Pointer access request |
| ptr_sel | input | 2 | Pointer: 0 X, 1 Y, 2 Z, 3 Z |
| ptr_mode | input | 2 | 0 plain, 1 post-increment, 2 pre-decrement, 3 offset |
| disp_q | input | 6 | Unsigned offset for offset mode |
| x_ptr | input | 16 | Current X pointer value |
| y_ptr | input | 16 | Current Y pointer value |
| z_ptr | input | 16 | Current Z pointer value |
| io_en | input | 1 | Port-style I/O access request |
| io_addr | input | 6 | I/O register number |
| push | input | 1 | Stack push strobe |
| pop | input | 1 | Stack pop strobe |
| sp_wr_lo | input | 1 | Load low byte of stack pointer |
| sp_wr_hi | input | 1 | Load high part of stack pointer |
| sp_wdata | input | 8 | Stack pointer load data |
| eff_addr | output | 16 | Effective data address |
| region | output | 3 | One-hot region: bit0 regs, bit1 I/O, bit2 SRAM |
| out_of_range | output | 1 | Address above top of SRAM |
| wb_en | output | 1 | Pointer write-back enable |
| wb_val | output | 16 | Updated pointer value |
| wb_reg | output | 5 | Low-byte register number of the selected pair |
| sp | output | 9 | Stack pointer |

## Verification
The hardest states to reach are the stack pointer at its wrap boundary and a push into the space above SRAM. Both depend on the register's history and cannot be set with one combinational input pattern. The bench first loads the two halves of the stack pointer in separate cycles. It pushes from 0 to force the wrap to 0x1FF, then pushes again to produce an out-of-range stack address. It also raises every source at once to show which one wins, and issues a load in the same cycle as a push.

// File: rtl/dag_pkg.sv
package dag_pkg;
   typedef enum logic [1:0] {
      AM_PLAIN   = 2'd0,
      AM_POSTINC = 2'd1,
      AM_PREDEC  = 2'd2,
      AM_DISP    = 2'd3
   } amode_e;

   localparam int RGN_RF   = 0;
   localparam int RGN_IO   = 1;
   localparam int RGN_SRAM = 2;
   localparam int RGN_N    = 3;
endpackage

// File: rtl/dag_ptr_mux.sv
module dag_ptr_mux
   import dag_pkg::*;
#(
   parameter int          PTR_W     = 16,
   parameter int          Q_W       = 6,
   parameter int          PAIR_BASE = 26,
   parameter logic [2:0]  DISP_MASK = 3'b110
) (
   input  logic [1:0]       sel,
   input  amode_e           mode,
   input  logic [Q_W-1:0]   q,
   input  logic [PTR_W-1:0] x_val,
   input  logic [PTR_W-1:0] y_val,
   input  logic [PTR_W-1:0] z_val,
   output logic [PTR_W-1:0] base,
   output logic [PTR_W-1:0] offs,
   output logic [4:0]       lo_reg
);
   localparam int NPTR = 3;

   logic [PTR_W-1:0] ptr_arr [NPTR];
   logic [NPTR-1:0]  disp_ok;
   logic [1:0]       idx;

   assign ptr_arr[0] = x_val;
   assign ptr_arr[1] = y_val;
   assign ptr_arr[2] = z_val;

   // Offset capability per pointer is a build-time choice.
   for (genvar i = 0; i < NPTR; i++) begin : g_disp
      if (DISP_MASK[i]) begin : g_on
         assign disp_ok[i] = 1'b1;
      end else begin : g_off
         assign disp_ok[i] = 1'b0;
      end
   end

   assign idx    = (sel == 2'd3) ? 2'd2 : sel;
   assign base   = ptr_arr[idx];
   assign offs   = (mode == AM_DISP && disp_ok[idx]) ? PTR_W'(q) : '0;
   assign lo_reg = 5'(PAIR_BASE) + {2'b00, idx, 1'b0};
endmodule

// File: rtl/dag_addr_calc.sv
module dag_addr_calc
   import dag_pkg::*;
#(
   parameter int PTR_W = 16
) (
   input  amode_e           mode,
   input  logic [PTR_W-1:0] base,
   input  logic [PTR_W-1:0] offs,
   output logic [PTR_W-1:0] addr,
   output logic [PTR_W-1:0] upd,
   output logic             upd_req
);
   localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

   always_comb begin
      addr    = base;
      upd     = base;
      upd_req = 1'b0;
      unique case (mode)
         AM_PLAIN: ;
         AM_POSTINC: begin
            upd     = base + ONE;
            upd_req = 1'b1;
         end
         AM_PREDEC: begin
            addr    = base - ONE;
            upd     = base - ONE;
            upd_req = 1'b1;
         end
         AM_DISP: addr = base + offs;
         default: ;
      endcase
   end
endmodule

// File: rtl/dag_region.sv
module dag_region
   import dag_pkg::*;
#(
   parameter int AW         = 16,
   parameter int RF_SIZE    = 32,
   parameter int IO_SIZE    = 64,
   parameter int SRAM_BYTES = 256
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               active,
   input  logic [AW-1:0]      addr,
   output logic [RGN_N-1:0]   region,
   output logic               oor
);
   localparam int IO_END   = RF_SIZE + IO_SIZE;
   localparam int SRAM_TOP = IO_END + SRAM_BYTES - 1;

   logic in_rf, in_io, in_sram;

   assign in_rf   = addr < AW'(RF_SIZE);
   assign in_io   = !in_rf && (addr < AW'(IO_END));
   assign in_sram = !in_rf && !in_io && (addr <= AW'(SRAM_TOP));

   always_comb begin
      region           = '0;
      region[RGN_RF]   = active && in_rf;
      region[RGN_IO]   = active && in_io;
      region[RGN_SRAM] = active && in_sram;
   end
   assign oor = active && !in_rf && !in_io && !in_sram;

   AST_REGION_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(region)); // R6
   AST_OOR_NO_REGION: assert property (@(posedge clk) disable iff (!rst_n)
      oor |-> (region == '0)); // R7
   AST_ACTIVE_DECODED: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> ($countones({region, oor}) == 1)); // R6
endmodule

// File: rtl/dag_stack.sv
module dag_stack #(
   parameter int SP_W = 9
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            push,
   input  logic            pop,
   input  logic            wr_lo,
   input  logic            wr_hi,
   input  logic [7:0]      wdata,
   output logic [SP_W-1:0] sp,
   output logic [SP_W-1:0] stk_addr
);
   localparam logic [SP_W-1:0] ONE = SP_W'(1);

   logic [SP_W-1:0] sp_q, sp_d, sp_inc;

   assign sp_inc   = sp_q + ONE;
   assign stk_addr = push ? sp_q : sp_inc;
   assign sp       = sp_q;

   always_comb begin
      sp_d = sp_q;
      if (wr_lo || wr_hi) begin
         if (wr_lo) sp_d[7:0] = wdata;
         if (wr_hi) sp_d[SP_W-1:8] = (SP_W-8)'(wdata);
      end else if (push) begin
         sp_d = sp_q - ONE;
      end else if (pop) begin
         sp_d = sp_inc;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sp_q <= '0;
      else        sp_q <= sp_d;
   end

   AST_PUSH_DEC: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !wr_lo && !wr_hi) |=> (sp == $past(sp) - ONE)); // R9
   AST_POP_INC: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && !wr_lo && !wr_hi) |=> (sp == $past(sp) + ONE)); // R10
   AST_SP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!push && !pop && !wr_lo && !wr_hi) |=> $stable(sp)); // R12
endmodule

// File: rtl/dag_top.sv
module dag_top
   import dag_pkg::*;
#(
   parameter int          PTR_W      = 16,
   parameter int          Q_W        = 6,
   parameter int          IO_AW      = 6,
   parameter int          SP_W       = 9,
   parameter int          RF_SIZE    = 32,
   parameter int          IO_SIZE    = 64,
   parameter int          SRAM_BYTES = 256,
   parameter int          PAIR_BASE  = 26,
   parameter logic [2:0]  DISP_MASK  = 3'b110
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ptr_en,
   input  logic [1:0]       ptr_sel,
   input  logic [1:0]       ptr_mode,
   input  logic [Q_W-1:0]   disp_q,
   input  logic [PTR_W-1:0] x_ptr,
   input  logic [PTR_W-1:0] y_ptr,
   input  logic [PTR_W-1:0] z_ptr,
   input  logic             io_en,
   input  logic [IO_AW-1:0] io_addr,
   input  logic             push,
   input  logic             pop,
   input  logic             sp_wr_lo,
   input  logic             sp_wr_hi,
   input  logic [7:0]       sp_wdata,
   output logic [PTR_W-1:0] eff_addr,
   output logic [2:0]       region,
   output logic             out_of_range,
   output logic             wb_en,
   output logic [PTR_W-1:0] wb_val,
   output logic [4:0]       wb_reg,
   output logic [SP_W-1:0]  sp
);
   localparam int SRAM_TOP = RF_SIZE + IO_SIZE + SRAM_BYTES - 1;

   if (SP_W < 9 || SP_W > PTR_W) begin : g_bad_spw
      $error("dag_top: SP_W must lie between 9 and PTR_W");
   end
   if (SRAM_TOP >= (1 << SP_W)) begin : g_bad_sram
      $error("dag_top: top of SRAM not reachable by the stack pointer");
   end
   if ((1 << IO_AW) != IO_SIZE) begin : g_bad_io
      $error("dag_top: IO_AW does not match IO_SIZE");
   end
   if (PAIR_BASE + 5 > 31 || PAIR_BASE % 2 != 0) begin : g_bad_pair
      $error("dag_top: pointer pairs must be even and inside 32 registers");
   end

   amode_e           mode;
   logic [PTR_W-1:0] base, offs, ptr_addr, upd;
   logic             upd_req;
   logic [SP_W-1:0]  stk_addr;
   logic             stk_sel, io_sel, ptr_win, active;

   assign mode    = amode_e'(ptr_mode);
   assign stk_sel = push || pop;
   assign io_sel  = !stk_sel && io_en;
   assign ptr_win = !stk_sel && !io_en && ptr_en;
   assign active  = stk_sel || io_en || ptr_en;

   dag_ptr_mux #(
      .PTR_W(PTR_W), .Q_W(Q_W), .PAIR_BASE(PAIR_BASE), .DISP_MASK(DISP_MASK)
   ) u_mux (
      .sel(ptr_sel), .mode(mode), .q(disp_q),
      .x_val(x_ptr), .y_val(y_ptr), .z_val(z_ptr),
      .base(base), .offs(offs), .lo_reg(wb_reg)
   );

   dag_addr_calc #(.PTR_W(PTR_W)) u_calc (
      .mode(mode), .base(base), .offs(offs),
      .addr(ptr_addr), .upd(upd), .upd_req(upd_req)
   );

   dag_stack #(.SP_W(SP_W)) u_stack (
      .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
      .wr_lo(sp_wr_lo), .wr_hi(sp_wr_hi), .wdata(sp_wdata),
      .sp(sp), .stk_addr(stk_addr)
   );

   always_comb begin
      if (stk_sel)     eff_addr = PTR_W'(stk_addr);
      else if (io_sel) eff_addr = PTR_W'(io_addr) + PTR_W'(RF_SIZE);
      else if (ptr_en) eff_addr = ptr_addr;
      else             eff_addr = '0;
   end

   assign wb_en  = ptr_win && upd_req;
   assign wb_val = upd;

   dag_region #(
      .AW(PTR_W), .RF_SIZE(RF_SIZE), .IO_SIZE(IO_SIZE), .SRAM_BYTES(SRAM_BYTES)
   ) u_region (
      .clk(clk), .rst_n(rst_n), .active(active), .addr(eff_addr),
      .region(region), .oor(out_of_range)
   );

   AST_WB_ONLY_PTR: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> (ptr_en && !push && !pop && !io_en)); // R11
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !(ptr_en || io_en || push || pop) |-> (region == 3'b000 && !out_of_range && !wb_en)); // R13
   AST_IO_REGION: assert property (@(posedge clk) disable iff (!rst_n)
      (io_en && !push && !pop) |-> (region == 3'b010)); // R8
   AST_DISP_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_mode == 2'd3) |-> !wb_en); // R4
endmodule

// File: tb/dag_top_tb_top.sv
module dag_top_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ptr_en = 0, io_en = 0, push = 0, pop = 0;
   logic        sp_wr_lo = 0, sp_wr_hi = 0;
   logic [1:0]  ptr_sel = 0, ptr_mode = 0;
   logic [5:0]  disp_q = 0, io_addr = 0;
   logic [15:0] x_ptr = 16'h001F, y_ptr = 16'h0058, z_ptr = 16'h015F;
   logic [7:0]  sp_wdata = 0;
   logic [15:0] eff_addr, wb_val;
   logic [2:0]  region;
   logic        out_of_range, wb_en;
   logic [4:0]  wb_reg;
   logic [8:0]  sp;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #4 clk = ~clk;

   dag_top dut_i (
      .clk(clk), .rst_n(rst_n), .ptr_en(ptr_en), .ptr_sel(ptr_sel),
      .ptr_mode(ptr_mode), .disp_q(disp_q), .x_ptr(x_ptr), .y_ptr(y_ptr),
      .z_ptr(z_ptr), .io_en(io_en), .io_addr(io_addr), .push(push), .pop(pop),
      .sp_wr_lo(sp_wr_lo), .sp_wr_hi(sp_wr_hi), .sp_wdata(sp_wdata),
      .eff_addr(eff_addr), .region(region), .out_of_range(out_of_range),
      .wb_en(wb_en), .wb_val(wb_val), .wb_reg(wb_reg), .sp(sp)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // sel, mode, q, addr, region, oor, wb_en, wb_val
   localparam int NV = 12;
   localparam logic [46:0] TBL [NV] = '{
      {2'd0, 2'd0, 6'd0,  16'h001F, 3'b001, 1'b0, 1'b0, 16'h0000}, // R1
      {2'd0, 2'd1, 6'd0,  16'h001F, 3'b001, 1'b0, 1'b1, 16'h0020}, // R2
      {2'd0, 2'd2, 6'd0,  16'h001E, 3'b001, 1'b0, 1'b1, 16'h001E}, // R3
      {2'd0, 2'd3, 6'd5,  16'h001F, 3'b001, 1'b0, 1'b0, 16'h0000}, // R4 X ignores q
      {2'd1, 2'd3, 6'd7,  16'h005F, 3'b010, 1'b0, 1'b0, 16'h0000}, // R4 R6
      {2'd1, 2'd3, 6'd8,  16'h0060, 3'b100, 1'b0, 1'b0, 16'h0000}, // R6
      {2'd1, 2'd1, 6'd0,  16'h0058, 3'b010, 1'b0, 1'b1, 16'h0059}, // R2 R5
      {2'd2, 2'd0, 6'd0,  16'h015F, 3'b100, 1'b0, 1'b0, 16'h0000}, // R6
      {2'd2, 2'd1, 6'd0,  16'h015F, 3'b100, 1'b0, 1'b1, 16'h0160}, // R2
      {2'd2, 2'd3, 6'd1,  16'h0160, 3'b000, 1'b1, 1'b0, 16'h0000}, // R7
      {2'd2, 2'd2, 6'd0,  16'h015E, 3'b100, 1'b0, 1'b1, 16'h015E}, // R3
      {2'd3, 2'd3, 6'd63, 16'h019E, 3'b000, 1'b1, 1'b0, 16'h0000}  // R5 R7
   };

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      if (!done) begin
         done = 1;
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R12 reset sp", 32'(sp), 32'h0);
      chk("R13 reset region", 32'(region), 32'h0);
      chk("R13 reset oor", 32'(out_of_range), 32'h0);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk("R13 idle wb_en", 32'(wb_en), 32'h0);

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         ptr_en = 1; ptr_sel = TBL[i][46:45]; ptr_mode = TBL[i][44:43];
         disp_q = TBL[i][42:37];
         #1;
         chk("R1-table addr", 32'(eff_addr), 32'(TBL[i][36:21]));
         chk("R6 region", 32'(region), 32'(TBL[i][20:18]));
         chk("R7 oor", 32'(out_of_range), 32'(TBL[i][17]));
         chk("R2 wb_en", 32'(wb_en), 32'(TBL[i][16]));
         if (TBL[i][16]) begin
            chk("R3 wb_val", 32'(wb_val), 32'(TBL[i][15:0]));
            chk("R5 wb_reg", 32'(wb_reg), 32'(26 + 2 * ((TBL[i][46:45] == 2'd3) ? 2 : TBL[i][46:45])));
         end
      end

      // Port-style accesses
      @(negedge clk);
      ptr_en = 0; io_en = 1; io_addr = 6'd0; #1;
      chk("R8 io low addr", 32'(eff_addr), 32'h20);
      chk("R8 io low region", 32'(region), 32'b010);
      io_addr = 6'd63; #1;
      chk("R8 io high addr", 32'(eff_addr), 32'h5F);
      ptr_en = 1; ptr_sel = 2'd1; ptr_mode = 2'd1; #1;
      chk("R11 io beats ptr", 32'(eff_addr), 32'h5F);
      chk("R11 no wb under io", 32'(wb_en), 32'h0);
      @(negedge clk);
      ptr_en = 0; io_en = 0;

      // Load stack pointer in two halves
      sp_wr_lo = 1; sp_wdata = 8'h5F;
      @(negedge clk);
      sp_wr_lo = 0; sp_wr_hi = 1; sp_wdata = 8'h01;
      @(negedge clk);
      sp_wr_hi = 0; #1;
      chk("R12 sp load", 32'(sp), 32'h15F);

      // Push then pop
      push = 1; #1;
      chk("R9 push addr", 32'(eff_addr), 32'h15F);
      chk("R9 push region", 32'(region), 32'b100);
      @(negedge clk);
      push = 0; #1;
      chk("R9 sp after push", 32'(sp), 32'h15E);
      pop = 1; #1;
      chk("R10 pop addr", 32'(eff_addr), 32'h15F);
      @(negedge clk);
      pop = 0; #1;
      chk("R10 sp after pop", 32'(sp), 32'h15F);

      // All sources at once
      push = 1; pop = 1; io_en = 1; ptr_en = 1; ptr_mode = 2'd1; #1;
      chk("R11 push wins addr", 32'(eff_addr), 32'h15F);
      chk("R11 push wins wb_en", 32'(wb_en), 32'h0);
      @(negedge clk);
      pop = 0; io_en = 0; ptr_en = 0; push = 0; #1;
      chk("R11 sp after combined", 32'(sp), 32'h15E);

      // Load beats push in same cycle
      push = 1; sp_wr_lo = 1; sp_wdata = 8'h00;
      @(negedge clk);
      push = 0; sp_wr_lo = 0; #1;
      chk("R12 load over push", 32'(sp), 32'h100);
      sp_wr_hi = 1; sp_wdata = 8'h00;
      @(negedge clk);
      sp_wr_hi = 0; #1;
      chk("R12 hi load", 32'(sp), 32'h000);

      // Wrap and out-of-range push
      push = 1; #1;
      chk("R9 push at zero addr", 32'(eff_addr), 32'h0);
      chk("R6 push at zero region", 32'(region), 32'b001);
      @(negedge clk); #1;
      chk("R9 sp wrap", 32'(sp), 32'h1FF);
      chk("R7 stack oor", 32'(out_of_range), 32'h1);
      chk("R7 stack oor region", 32'(region), 32'h0);
      @(negedge clk);
      push = 0; #1;
      chk("R9 sp after oor push", 32'(sp), 32'h1FE);
      chk("R13 idle again", 32'(region), 32'h0);

      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule